// File: doc/BRIEF.md
# Control Endpoint Transfer Sequencer

This block follows the default control endpoint of a USB device through the stages of each control transfer. Event pulses from the packet engine (a SETUP arrived, a data packet was sent, a data packet was received, the final IN transfer completed) and from the request handler (halt the endpoint, release a held status stage) move a small state machine. Its outputs are the current stage as a 3-bit code, a level that tells the packet engine to answer with a STALL handshake, and a one-cycle pulse that starts the status stage.

A data stage ends once the bytes moved reach the length announced in the SETUP, or when a packet shorter than the maximum packet size arrives. After the last IN packet the block waits in its own stage for the completion interrupt. A request handler that needs time before it acknowledges can ask, together with the SETUP, for the status stage to be held. The status pulse then waits for an explicit release. A halted endpoint leaves the halt by itself when the next SETUP is seen.

The block also holds a 6-byte response store that firmware fills with short replies the device answers itself. Six bytes cover the largest such payload, and a 2-byte status reply uses the low bytes.

Top module: `ctl_ep_seq`

## Requirements
- R1: After reset the stage code is 1 (SETUP), `stall_hs` is 0 and `status_go` is 0. The stage codes are SETUP=1, IN data=2, OUT data=3, IN done=4, HALT=5, and no other code appears.
- R2: A `setup_evt` with nonzero `setup_len` moves the stage to 2 when `setup_dir_in` is 1 and to 3 when it is 0. The new stage is visible one cycle after the pulse.
- R3: A `setup_evt` with `setup_len` of 0 leaves the stage at 1. When `setup_defer` is 0 it raises `status_go` for exactly one cycle, starting the cycle after the SETUP.
- R4: In stage 2 each `pkt_tx` adds `pkt_bytes` to a running count. When the count reaches `setup_len`, or `pkt_bytes` is less than MAXP (64 by default), the stage becomes 4. Otherwise it stays 2.
- R5: Stage 4 holds until `xfer_done`, then returns to 1 without a `status_go` pulse.
- R6: In stage 3 each `pkt_rx` ends the stage under the same rule as R4. The stage returns to 1 and `status_go` pulses for one cycle, unless the status stage is held.
- R7: `stall_req` moves any stage to 5. `stall_hs` is 1 exactly while the stage is 5. A `setup_evt` in stage 5, or in the same cycle as `stall_req`, is handled as in R2 and R3.
- R8: When a SETUP carries `setup_defer`=1, the status pulse that R3 or R6 would give is withheld. `status_go` pulses one cycle after the next `status_release` instead. A `status_release` with nothing held has no effect.
- R9: An event that does not belong to the current stage changes neither the stage nor `status_go`: `pkt_tx` outside stage 2, `pkt_rx` outside stage 3, and `xfer_done` outside stage 4.
- R10: The response store has 6 bytes at addresses 0 to 5. `rb_rdata` shows the byte at `rb_addr` with no delay. Writes to addresses 6 and 7 are dropped, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_evt | input | 1 | SETUP packet received (pulse) |
| setup_len | input | 16 | Data stage length from the SETUP |
| setup_dir_in | input | 1 | 1: data stage is device-to-host |
| setup_defer | input | 1 | Hold the status stage for this request |
| pkt_tx | input | 1 | Data packet sent to host (pulse) |
| pkt_rx | input | 1 | Data packet received from host (pulse) |
| pkt_bytes | input | 7 | Byte count of the packet in pkt_tx/pkt_rx |
| xfer_done | input | 1 | Completion interrupt for last IN packet |
| stall_req | input | 1 | Halt the endpoint (pulse) |
| status_release | input | 1 | Release a held status stage (pulse) |
| rb_we | input | 1 | Response store write enable |
| rb_addr | input | 3 | Response store byte address |
| rb_wdata | input | 8 | Response store write data |
| rb_rdata | output | 8 | Response store read data |
| stage | output | 3 | Current stage code |
| stall_hs | output | 1 | Answer with STALL handshake |
| status_go | output | 1 | Start status stage (one-cycle pulse) |

## Verification
The hardest situation to reach from the ports is a held status stage that is released only after several idle cycles. It has to be shown that the pulse is withheld at the moment the data stage ends, that it stays absent during the wait, and that a second release does nothing. The stimulus reaches this case through two separate routes: a deferred zero-length SETUP, and a deferred OUT transfer that ends on an exact-length full packet. A SETUP and a halt request arriving in the same cycle are also driven together, to check which of the two takes effect.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic [2:0] {
    ST_SETUP   = 3'd1,
    ST_IN      = 3'd2,
    ST_OUT     = 3'd3,
    ST_IN_DONE = 3'd4,
    ST_HALT    = 3'd5
  } ep_stage_e;
endpackage

// File: rtl/ctl_ep_bytecnt.sv
module ctl_ep_bytecnt #(
  parameter int LEN_W = 16,
  parameter int MAXP  = 64,
  localparam int PKT_W = $clog2(MAXP) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] req_len,
  input  logic             acc,
  input  logic [PKT_W-1:0] pkt_bytes,
  output logic             last
);
  logic [LEN_W-1:0] req_q;
  logic [LEN_W:0]   cnt_q, cnt_d, sum;

  assign sum  = cnt_q + {{(LEN_W+1-PKT_W){1'b0}}, pkt_bytes};
  assign last = (sum >= {1'b0, req_q}) || (pkt_bytes < PKT_W'(MAXP));

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = '0;
    else if (acc) cnt_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (load) req_q <= req_len;
    end
  end
endmodule

// File: rtl/ctl_ep_respbuf.sv
module ctl_ep_respbuf #(
  parameter int DEPTH = 6,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];
  logic       hit;

  assign hit   = (32'(addr) < DEPTH);
  assign rdata = hit ? mem_q[addr] : 8'h00;

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    logic wen;
    assign wen = we && (32'(addr) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[i] <= 8'h00;
      else if (wen) mem_q[i] <= wdata;
    end
  end

  assert_rb_oob_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdata == 8'h00);
endmodule

// File: rtl/ctl_ep_fsm.sv
module ctl_ep_fsm
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_evt,
  input  logic [LEN_W-1:0] setup_len,
  input  logic             setup_dir_in,
  input  logic             setup_defer,
  input  logic             pkt_tx,
  input  logic             pkt_rx,
  input  logic             xfer_done,
  input  logic             stall_req,
  input  logic             status_release,
  input  logic             last,
  output logic             acc,
  output ep_stage_e        stage,
  output logic             status_go
);
  ep_stage_e st_q, st_d;
  logic pend_q, pend_d, defer_q, defer_d, go_q, go_d;

  assign acc = !setup_evt && !stall_req &&
               ((pkt_tx && st_q == ST_IN) || (pkt_rx && st_q == ST_OUT));

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    defer_d = defer_q;
    go_d    = 1'b0;
    if (setup_evt) begin
      defer_d = setup_defer;
      pend_d  = 1'b0;
      if (setup_len == '0) begin
        st_d = ST_SETUP;
        if (setup_defer) pend_d = 1'b1;
        else             go_d   = 1'b1;
      end else begin
        st_d = setup_dir_in ? ST_IN : ST_OUT;
      end
    end else if (stall_req) begin
      st_d   = ST_HALT;
      pend_d = 1'b0;
    end else begin
      case (st_q)
        ST_IN:      if (pkt_tx && last) st_d = ST_IN_DONE;
        ST_IN_DONE: if (xfer_done) st_d = ST_SETUP;
        ST_OUT: if (pkt_rx && last) begin
          st_d = ST_SETUP;
          if (defer_q) pend_d = 1'b1;
          else         go_d   = 1'b1;
        end
        ST_SETUP: if (status_release && pend_q) begin
          go_d   = 1'b1;
          pend_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SETUP;
      pend_q  <= 1'b0;
      defer_q <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      defer_q <= defer_d;
      go_q    <= go_d;
    end
  end

  assign stage     = st_q;
  assign status_go = go_q;

  assert_stage_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stage inside {ST_SETUP, ST_IN, ST_OUT, ST_IN_DONE, ST_HALT});
  assert_in_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_IN_DONE && !setup_evt && !stall_req && !xfer_done)
    |=> stage == ST_IN_DONE);
  assert_halt_leaves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_HALT && setup_evt) |=> stage != ST_HALT);
  assert_defer_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_evt && setup_defer && setup_len == '0) |=> !status_go);
  assert_go_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_go |=> !status_go);
endmodule

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MAXP     = 64,
  parameter int RB_DEPTH = 6,
  localparam int PKT_W   = $clog2(MAXP) + 1,
  localparam int RB_AW   = $clog2(RB_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_evt,
  input  logic [LEN_W-1:0] setup_len,
  input  logic             setup_dir_in,
  input  logic             setup_defer,
  input  logic             pkt_tx,
  input  logic             pkt_rx,
  input  logic [PKT_W-1:0] pkt_bytes,
  input  logic             xfer_done,
  input  logic             stall_req,
  input  logic             status_release,
  input  logic             rb_we,
  input  logic [RB_AW-1:0] rb_addr,
  input  logic [7:0]       rb_wdata,
  output logic [7:0]       rb_rdata,
  output logic [2:0]       stage,
  output logic             stall_hs,
  output logic             status_go
);
  logic      last, acc;
  ep_stage_e st;

  ctl_ep_bytecnt #(.LEN_W(LEN_W), .MAXP(MAXP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(setup_evt), .req_len(setup_len),
    .acc(acc), .pkt_bytes(pkt_bytes), .last(last));

  ctl_ep_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .setup_evt(setup_evt), .setup_len(setup_len),
    .setup_dir_in(setup_dir_in), .setup_defer(setup_defer),
    .pkt_tx(pkt_tx), .pkt_rx(pkt_rx), .xfer_done(xfer_done),
    .stall_req(stall_req), .status_release(status_release), .last(last),
    .acc(acc), .stage(st), .status_go(status_go));

  ctl_ep_respbuf #(.DEPTH(RB_DEPTH), .AW(RB_AW)) u_rb (
    .clk(clk), .rst_n(rst_n), .we(rb_we), .addr(rb_addr),
    .wdata(rb_wdata), .rdata(rb_rdata));

  assign stage    = st;
  assign stall_hs = (st == ST_HALT);

  assert_halt_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && !setup_evt) |=> stall_hs);
endmodule

// File: tb/ctl_ep_seq_tb.sv
module ctl_ep_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic setup_evt = 0, setup_dir_in = 0, setup_defer = 0;
  logic [15:0] setup_len = '0;
  logic pkt_tx = 0, pkt_rx = 0, xfer_done = 0, stall_req = 0, status_release = 0;
  logic [6:0] pkt_bytes = '0;
  logic rb_we = 0;
  logic [2:0] rb_addr = '0;
  logic [7:0] rb_wdata = '0, rb_rdata;
  logic [2:0] stage;
  logic stall_hs, status_go;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ctl_ep_seq u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    setup_evt = 0; setup_defer = 0; pkt_tx = 0; pkt_rx = 0;
    xfer_done = 0; stall_req = 0; status_release = 0; rb_we = 0;
  endtask

  task automatic do_setup(int len, bit din, bit dfr);
    @(negedge clk);
    setup_evt = 1; setup_len = 16'(len); setup_dir_in = din; setup_defer = dfr;
    @(negedge clk); clr();
  endtask

  task automatic do_tx(int n);
    @(negedge clk); pkt_tx = 1; pkt_bytes = 7'(n);
    @(negedge clk); clr();
  endtask

  task automatic do_rx(int n);
    @(negedge clk); pkt_rx = 1; pkt_bytes = 7'(n);
    @(negedge clk); clr();
  endtask

  task automatic do_done();
    @(negedge clk); xfer_done = 1; @(negedge clk); clr();
  endtask

  task automatic do_stall();
    @(negedge clk); stall_req = 1; @(negedge clk); clr();
  endtask

  task automatic do_release();
    @(negedge clk); status_release = 1; @(negedge clk); clr();
  endtask

  task automatic t_reset();
    chk("R1 stage", stage, 1);
    chk("R1 stall", stall_hs, 0);
    chk("R1 go", status_go, 0);
  endtask

  task automatic t_zero_len();
    do_setup(0, 0, 0);
    chk("R3 stage", stage, 1);
    chk("R3 go", status_go, 1);
    @(negedge clk);
    chk("R3 go single", status_go, 0);
  endtask

  task automatic t_in_short();
    do_setup(100, 1, 0);
    chk("R2 in", stage, 2);
    do_tx(64);
    chk("R4 mid", stage, 2);
    do_rx(10);
    chk("R9 rx in IN", stage, 2);
    do_tx(36);
    chk("R4 short end", stage, 4);
    do_tx(64);
    chk("R9 tx in IN_DONE", stage, 4);
    @(negedge clk); @(negedge clk);
    chk("R5 hold", stage, 4);
    do_done();
    chk("R5 back", stage, 1);
    chk("R5 no go", status_go, 0);
  endtask

  task automatic t_in_exact();
    do_setup(128, 1, 0);
    do_tx(64);
    chk("R4 exact mid", stage, 2);
    do_tx(64);
    chk("R4 exact end", stage, 4);
    do_done();
    chk("R5 exact back", stage, 1);
  endtask

  task automatic t_out();
    do_setup(10, 0, 0);
    chk("R2 out", stage, 3);
    do_tx(5);
    chk("R9 tx in OUT", stage, 3);
    do_done();
    chk("R9 done in OUT", stage, 3);
    do_rx(10);
    chk("R6 end", stage, 1);
    chk("R6 go", status_go, 1);
    do_release();
    chk("R8 idle release", status_go, 0);
  endtask

  task automatic t_out_defer();
    do_setup(64, 0, 1);
    do_rx(64);
    chk("R6 defer stage", stage, 1);
    chk("R8 held", status_go, 0);
    repeat (3) @(negedge clk);
    chk("R8 still held", status_go, 0);
    do_release();
    chk("R8 released", status_go, 1);
    do_release();
    chk("R8 second release", status_go, 0);
  endtask

  task automatic t_zero_defer();
    do_setup(0, 0, 1);
    chk("R8 zero held", status_go, 0);
    do_release();
    chk("R8 zero released", status_go, 1);
  endtask

  task automatic t_stall();
    do_setup(20, 0, 0);
    do_stall();
    chk("R7 halt", stage, 5);
    chk("R7 stall_hs", stall_hs, 1);
    do_rx(20);
    chk("R9 rx in HALT", stage, 5);
    chk("R9 no go in HALT", status_go, 0);
    do_setup(0, 0, 0);
    chk("R7 cleared", stage, 1);
    chk("R7 stall_hs low", stall_hs, 0);
    chk("R7 go", status_go, 1);
    @(negedge clk);
    setup_evt = 1; stall_req = 1; setup_len = 16'd8; setup_dir_in = 1;
    @(negedge clk); clr();
    chk("R7 setup wins", stage, 2);
    do_stall();
    chk("R7 halt from IN", stall_hs, 1);
    do_setup(0, 0, 0);
  endtask

  task automatic t_respbuf();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rb_we = 1; rb_addr = 3'(i); rb_wdata = 8'(8'hA0 + i);
    end
    @(negedge clk); rb_we = 1; rb_addr = 3'd6; rb_wdata = 8'h55;
    @(negedge clk); rb_we = 1; rb_addr = 3'd7; rb_wdata = 8'h66;
    @(negedge clk); clr();
    for (int i = 0; i < 8; i++) begin
      rb_addr = 3'(i); #1;
      chk("R10 read", rb_rdata, (i < 6) ? (8'hA0 + i) : 0);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_in_short();
    t_in_exact();
    t_out();
    t_out_defer();
    t_zero_defer();
    t_stall();
    t_respbuf();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule